// File: doc/BRIEF.md
# Serial Word Data-Clock and Ready Generator

This block follows an FSK demodulator. It watches the recovered asynchronous bit stream, which carries 10-bit words at roughly 1200 baud: one low start bit, eight data bits sent least significant bit first, and one high stop bit. The block does not build a parallel byte. For each word it produces a burst of active-low clock pulses, one for each data bit, with each rising edge placed at the centre of its bit. After the last pulse it drives an active-low ready strobe. An external shift register clocks the bits in on the pulse edges and latches the byte on the ready strobe.

The bit period is a parameter given in master-clock cycles. The default of 2976 gives about 1202.8 Hz from a 3.5795 MHz reference. A falling edge on the line is accepted as a start bit only if the line is still low half a bit later. While a word is in progress, further edges on the line are ignored. The serial data output is forced high while the carrier flag is inactive. The whole sequencer is also held idle during that time.

Top module: `word_clock_gen`

## Requirements
- R1: During reset and directly after it, `data_o`, `dclk_no` and `drdy_no` are all high.
- R2: While `carrier_i` is low, `data_o` is 1. While `carrier_i` is high, `data_o` follows `rx_i` through the two-stage synchronizer plus one output register (a mark, logic 1, gives 1; a space gives 0).
- R3: A word starts when `carrier_i` is high, the sequencer is idle, and the synchronized line falls from 1 to 0. If the line is high again at the half-bit check point, the event is treated as a glitch: no pulses and no ready change follow.
- R4: Let edge n be the first clock edge at which `rx_i` is sampled low for an accepted start. Then `dclk_no` falls at edge n+2+BIT_DIV*(1+k) and rises at edge n+2+BIT_DIV*(1+k)+BIT_DIV/2, for k = 0..DATA_BITS-1.
- R5: Exactly DATA_BITS clock pulses are produced per word, none during the start or stop bit. `dclk_no` is high whenever no word is in progress. Falling edges on the line inside a word start nothing.
- R6: `drdy_no` falls at the same edge as the final rise of `dclk_no`. It stays low until the next confirmed start, then rises at edge n+2+BIT_DIV/2.
- R7: When `carrier_i` is sampled low, any word in progress is abandoned and `dclk_no` and `drdy_no` are high from the next edge. No start is accepted while the carrier is low.
- R8: BIT_DIV (default 2976) must be even and at least 4. DATA_BITS must be at least 1. SYNC_STAGES must be at least 2. Elaboration rejects any other values.
- R9: At each rising edge of `dclk_no`, `data_o` holds data bit k of the word (bit 0 first).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Demodulated serial bit (mark = 1) |
| carrier_i | input | 1 | Carrier present flag, active high |
| data_o | output | 1 | Carrier-gated serial data |
| dclk_no | output | 1 | Active-low data clock, one pulse per data bit |
| drdy_no | output | 1 | Active-low data ready, asserted after the last pulse |

## Verification
The bench sends back-to-back words whose data bits contain many falling edges. If the design retriggered inside a word, it would produce extra pulses or shift later bursts. The bench also sends a short low glitch while ready is asserted: a design that skipped the half-bit check would emit a bogus burst, and one that cleared ready too early would release the strobe. Each pulse edge is checked at its exact cycle, so a pulse whose width or phase is off by one half-bit shows up at once. At every rise the data bit is compared, which catches a reversed bit order. Dropping the carrier while ready is low, and sending a whole word with the carrier absent, shows whether ready is released and whether the data output and the sequencer stay quiet.

// File: rtl/wcg_pkg.sv
package wcg_pkg;

   typedef enum logic {
      SEQ_IDLE = 1'b0,
      SEQ_BUSY = 1'b1
   } seq_state_e;

endpackage

// File: rtl/wcg_rx_sync.sv
module wcg_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   output logic rx_s_o,
   output logic fall_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '1;
         prev_q  <= 1'b1;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], rx_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rx_s_o = chain_q[STAGES-1];
   assign fall_o = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/wcg_half_timer.sv
module wcg_half_timer #(
   parameter int unsigned HALF = 1488
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   input  logic run_i,
   output logic tick_o
);

   localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(HALF - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (start_i || !run_i) begin
         cnt_q <= '0;
      end else if (cnt_q == CNT_LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign tick_o = run_i && (cnt_q == CNT_LAST);

   // R4: the half-bit counter never passes its terminal count
   assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= CNT_LAST);

endmodule

// File: rtl/wcg_word_seq.sv
module wcg_word_seq
   import wcg_pkg::*;
#(
   parameter int unsigned DATA_BITS = 8
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic carrier_i,
   input  logic rx_s_i,
   input  logic fall_i,
   input  logic tick_i,
   output logic start_o,
   output logic run_o,
   output logic dclk_no,
   output logic drdy_no
);

   localparam int unsigned CONFIRM_TICK = 1;
   localparam int unsigned LAST_PULSE   = 2 * DATA_BITS + 1;
   localparam int unsigned END_TICK     = LAST_PULSE + 2;
   localparam int unsigned HW           = $clog2(END_TICK + 1);

   seq_state_e    state_q;
   logic [HW-1:0] hcnt_q;
   logic [HW-1:0] hnext;
   logic          dclk_q;
   logic          drdy_q;

   assign hnext   = hcnt_q + 1'b1;
   assign start_o = (state_q == SEQ_IDLE) && fall_i && carrier_i;
   assign run_o   = (state_q == SEQ_BUSY);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= SEQ_IDLE;
         hcnt_q  <= '0;
         dclk_q  <= 1'b1;
         drdy_q  <= 1'b1;
      end else if (!carrier_i) begin
         state_q <= SEQ_IDLE;
         hcnt_q  <= '0;
         dclk_q  <= 1'b1;
         drdy_q  <= 1'b1;
      end else begin
         unique case (state_q)
            SEQ_IDLE: begin
               if (fall_i) begin
                  state_q <= SEQ_BUSY;
                  hcnt_q  <= '0;
               end
            end
            SEQ_BUSY: begin
               if (tick_i) begin
                  hcnt_q <= hnext;
                  if (hnext == HW'(CONFIRM_TICK)) begin
                     if (rx_s_i) state_q <= SEQ_IDLE;
                     else        drdy_q  <= 1'b1;
                  end else if (hnext <= HW'(LAST_PULSE)) begin
                     dclk_q <= hnext[0];
                     if (hnext == HW'(LAST_PULSE)) drdy_q <= 1'b0;
                  end else if (hnext == HW'(END_TICK)) begin
                     state_q <= SEQ_IDLE;
                  end
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign dclk_no = dclk_q;
   assign drdy_no = drdy_q;

   // R5: no clock pulse outside a word
   assert_idle_clk_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == SEQ_IDLE) |-> dclk_q);

   // R6: ready is only asserted while the clock rests high
   assert_ready_clk_high_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !drdy_q |-> dclk_q);

   // R7: a lost carrier releases both strobes and idles the sequencer
   assert_carrier_abort_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carrier_i |=> (dclk_q && drdy_q && state_q == SEQ_IDLE));

   // R4: the clock only moves on a half-bit tick or a carrier loss
   assert_clk_on_tick_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(dclk_q) |-> ($past(tick_i) || !$past(carrier_i)));

endmodule

// File: rtl/word_clock_gen.sv
module word_clock_gen #(
   parameter int unsigned BIT_DIV     = 2976,
   parameter int unsigned DATA_BITS   = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rx_i,
   input  logic carrier_i,
   output logic data_o,
   output logic dclk_no,
   output logic drdy_no
);

   localparam int unsigned HALF = BIT_DIV / 2;

   // R8: parameter legality
   generate
      if ((BIT_DIV % 2) != 0 || BIT_DIV < 4) begin : g_bad_div
         $error("word_clock_gen: BIT_DIV must be even and >= 4");
      end
      if (DATA_BITS < 1) begin : g_bad_bits
         $error("word_clock_gen: DATA_BITS must be >= 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("word_clock_gen: SYNC_STAGES must be >= 2");
      end
   endgenerate

   logic rx_s;
   logic fall;
   logic start;
   logic run;
   logic tick;
   logic data_q;

   wcg_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rx_i   (rx_i),
      .rx_s_o (rx_s),
      .fall_o (fall)
   );

   wcg_half_timer #(.HALF(HALF)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (start),
      .run_i   (run),
      .tick_o  (tick)
   );

   wcg_word_seq #(.DATA_BITS(DATA_BITS)) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .carrier_i (carrier_i),
      .rx_s_i    (rx_s),
      .fall_i    (fall),
      .tick_i    (tick),
      .start_o   (start),
      .run_o     (run),
      .dclk_no   (dclk_no),
      .drdy_no   (drdy_no)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) data_q <= 1'b1;
      else         data_q <= carrier_i ? rx_s : 1'b1;
   end

   assign data_o = data_q;

   // R2: output is forced to mark while the carrier is absent
   assert_data_gated_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !carrier_i |=> data_o);

endmodule

// File: tb/word_clock_gen_bench.sv
module word_clock_gen_bench;

   localparam int BIT_DIV = 16;
   localparam int HALF    = BIT_DIV / 2;
   localparam int NBITS   = 8;

   typedef struct packed {
      logic        kind;   // 0: data clock, 1: ready
      logic        level;
      logic [31:0] cyc;
      logic        chk;
      logic        dat;
   } ev_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx = 1'b1;
   logic car = 1'b0;
   logic data;
   logic dclk_n;
   logic drdy_n;

   int   cyc = 0;
   int   checks = 0;
   int   errors = 0;
   bit   dr_exp_low = 1'b0;
   bit   mon_en = 1'b0;
   bit   done = 1'b0;
   ev_t  exp_q[$];

   logic p_dclk = 1'b1;
   logic p_dr = 1'b1;
   logic p_car = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   word_clock_gen #(.BIT_DIV(BIT_DIV), .DATA_BITS(NBITS), .SYNC_STAGES(2)) u_word_clock_gen (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .rx_i      (rx),
      .carrier_i (car),
      .data_o    (data),
      .dclk_no   (dclk_n),
      .drdy_no   (drdy_n)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic push(input logic kind, input logic level, input int c,
                       input logic ck, input logic d);
      ev_t e;
      e.kind = kind; e.level = level; e.cyc = c; e.chk = ck; e.dat = d;
      exp_q.push_back(e);
   endtask

   task automatic observe(input logic kind, input logic level);
      ev_t e;
      string req;
      req = kind ? "R6" : "R4";
      if (exp_q.size() == 0) begin
         chk(1'b0, "R5", kind ? "unexpected ready edge" : "unexpected clock edge",
             int'(level), int'(!level));
      end else begin
         e = exp_q.pop_front();
         chk(e.kind == kind && e.level == level, req, "edge kind/level",
             int'({kind, level}), int'({e.kind, e.level}));
         chk(int'(e.cyc) == cyc, req, "edge cycle", cyc, int'(e.cyc));
         if (e.chk) chk(data == e.dat, "R9", "data at clock rise", int'(data), int'(e.dat));
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (mon_en) begin
         if (dclk_n !== p_dclk) observe(1'b0, dclk_n);
         if (drdy_n !== p_dr)   observe(1'b1, drdy_n);
         if (!car && !p_car) chk(data === 1'b1, "R2", "data gated high", int'(data), 1);
         p_dclk = dclk_n;
         p_dr   = drdy_n;
         p_car  = car;
      end
   end

   // driver: one 10-bit word, with expected events when a burst is due
   task automatic send_word(input logic [7:0] b, input bit burst);
      int n;
      @(negedge clk);
      n = cyc + 1;
      if (burst) begin
         if (dr_exp_low) push(1'b1, 1'b1, n + 2 + HALF, 1'b0, 1'b0);   // R6 release
         dr_exp_low = 1'b0;
         for (int k = 0; k < NBITS; k++) begin
            push(1'b0, 1'b0, n + 2 + (2 + 2*k) * HALF, 1'b0, 1'b0);    // R4 fall
            push(1'b0, 1'b1, n + 2 + (3 + 2*k) * HALF, 1'b1, b[k]);    // R4/R9 rise
         end
         push(1'b1, 1'b0, n + 2 + (2*NBITS + 1) * HALF, 1'b0, 1'b0);   // R6 assert
         dr_exp_low = 1'b1;
      end
      rx = 1'b0;
      repeat (BIT_DIV) @(negedge clk);
      for (int k = 0; k < NBITS; k++) begin
         rx = b[k];
         repeat (BIT_DIV) @(negedge clk);
      end
      rx = 1'b1;
      repeat (BIT_DIV - 1) @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk(dclk_n === 1'b1, "R1", "dclk_no in reset", int'(dclk_n), 1);
      chk(drdy_n === 1'b1, "R1", "drdy_no in reset", int'(drdy_n), 1);
      chk(data === 1'b1, "R1", "data_o in reset", int'(data), 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk(dclk_n === 1'b1 && drdy_n === 1'b1 && data === 1'b1, "R1",
          "outputs after reset", int'({dclk_n, drdy_n, data}), 7);
      mon_en = 1'b1;
      repeat (3) @(negedge clk);
      car = 1'b1;
      repeat (10) @(negedge clk);

      // R3/R4/R5/R9: words back to back, data full of falling edges
      send_word(8'h55, 1'b1);
      send_word(8'hA3, 1'b1);
      send_word(8'h00, 1'b1);
      repeat (7) @(negedge clk);
      send_word(8'hFF, 1'b1);
      repeat (10) @(negedge clk);

      // R3: short low glitch, ready must stay asserted
      rx = 1'b0;
      repeat (2) @(negedge clk);
      rx = 1'b1;
      repeat (40) @(negedge clk);
      chk(drdy_n === 1'b0, "R3", "ready held over glitch", int'(drdy_n), 0);
      chk(dclk_n === 1'b1, "R3", "no pulse from glitch", int'(dclk_n), 1);
      send_word(8'h3C, 1'b1);
      repeat (10) @(negedge clk);

      // R7: carrier loss releases ready on the next edge
      car = 1'b0;
      push(1'b1, 1'b1, cyc + 1, 1'b0, 1'b0);
      dr_exp_low = 1'b0;
      repeat (5) @(negedge clk);
      // R7: a full word without carrier makes no burst
      send_word(8'h81, 1'b0);
      repeat (5) @(negedge clk);
      chk(dclk_n === 1'b1 && drdy_n === 1'b1, "R7", "quiet without carrier",
          int'({dclk_n, drdy_n}), 3);
      car = 1'b1;
      repeat (10) @(negedge clk);
      send_word(8'h96, 1'b1);
      repeat (40) @(negedge clk);

      chk(exp_q.size() == 0, "R5", "events left unseen", exp_q.size(), 0);
      finish_run();
   end

endmodule